// File: doc/BRIEF.md
# XAUI-to-XGMII Receive Code Translator

This block sits on the receive path of a 10 Gb/s extender sublayer, after the 8b/10b decoder and lane deskew. Each beat carries a fixed number of byte lanes (eight by default), and each lane holds one decoded octet, one control flag and one decode-error flag. Every lane is rewritten independently into the matching XGMII data or control code.

The three ordered-set fill characters seen on the serial side are comma (0xBC), skip (0x1C) and alignment (0x7C). All three collapse into the single XGMII Idle code. Start, Sequence, Terminate and Error keep their code values. Start and Sequence may only appear in lane 0. Anything the block cannot place legally, and any lane flagged by the decoder, leaves as the Error code.

The block is one registered stage with valid/ready handshakes on both sides. A beat is taken when `in_valid` and `in_ready` are both high at a clock edge. The block raises `in_ready` whenever its output register is empty, or is being drained in the same cycle. A beat held on the output while `out_ready` is low stays unchanged until the downstream stage takes it. `in_ready` does not depend on `in_valid`.

Top module: `xgmii_rx_xlate`

## Requirements
- R1: Lane i occupies bits [8i+7:8i] of the data buses and bit i of the flag buses. A lane with control flag 0 and no decode error leaves with its octet unchanged and control flag 0.
- R2: A control lane holding 0xBC, 0x1C or 0x7C leaves as Idle: 0x07 with control flag 1.
- R3: A control lane holding 0xFD (Terminate) or 0xFE (Error) leaves unchanged with control flag 1, in any lane.
- R4: A control lane holding 0xFB (Start) or 0x9C (Sequence) leaves unchanged in lane 0. In any other lane it leaves as 0xFE with control flag 1.
- R5: A control lane holding any value not named in R2 to R4 (for example 0x00, 0x07, 0xFC or 0xFF) leaves as 0xFE with control flag 1.
- R6: A lane with its decode-error flag set leaves as 0xFE with control flag 1, whatever its octet and control flag are.
- R7: An accepted beat appears on the outputs with `out_valid` high at the next clock edge. With no new beat accepted and the output taken, `out_valid` falls.
- R8: While `out_valid` is high and `out_ready` is low, the output beat holds stable. `in_ready` is high exactly when the output register is empty or is being taken.
- R9: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_data | input | LANES*8 | Decoded octets, lane 0 in the low byte |
| in_ctrl | input | LANES | Per-lane control flag |
| in_derr | input | LANES | Per-lane 8b/10b decode error |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | LANES*8 | XGMII octets |
| out_ctrl | output | LANES | XGMII per-lane control flag |

## Verification
The bench builds the block with the default of eight lanes. At this width, the lane-0 rule for Start and Sequence can be tested against seven non-leading lanes at once, and every fill, reserved and error case can be mixed inside a single beat. Directed beats run with `out_ready` held high, so the one-cycle latency can be observed. A random phase then stalls `out_ready` on about a third of cycles, which exercises holding and refilling of the output register.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int unsigned OCT_W = 8;

  // serial-side control characters after decoding
  localparam logic [OCT_W-1:0] SER_COMMA = 8'hBC;
  localparam logic [OCT_W-1:0] SER_SKIP  = 8'h1C;
  localparam logic [OCT_W-1:0] SER_ALIGN = 8'h7C;

  // XGMII control codes
  localparam logic [OCT_W-1:0] XG_IDLE  = 8'h07;
  localparam logic [OCT_W-1:0] XG_SEQ   = 8'h9C;
  localparam logic [OCT_W-1:0] XG_START = 8'hFB;
  localparam logic [OCT_W-1:0] XG_TERM  = 8'hFD;
  localparam logic [OCT_W-1:0] XG_ERR   = 8'hFE;

  typedef struct packed {
    logic             ctl;
    logic [OCT_W-1:0] oct;
  } lane_t;
endpackage

// File: rtl/xlt_lane_map.sv
module xlt_lane_map
  import xlt_pkg::*;
#(
  parameter int unsigned LANE_IDX = 0
) (
  input  logic [OCT_W-1:0] oct_in,
  input  logic             ctl_in,
  input  logic             err_in,
  output lane_t            lane_out
);
  localparam bit LEADING = (LANE_IDX == 0);

  always_comb begin
    lane_out.ctl = 1'b1;
    lane_out.oct = XG_ERR;
    if (err_in) begin
      lane_out.oct = XG_ERR;
    end else if (!ctl_in) begin
      lane_out.ctl = 1'b0;
      lane_out.oct = oct_in;
    end else begin
      case (oct_in)
        SER_COMMA, SER_SKIP, SER_ALIGN: lane_out.oct = XG_IDLE;
        XG_TERM, XG_ERR:                lane_out.oct = oct_in;
        XG_START, XG_SEQ:               lane_out.oct = LEADING ? oct_in : XG_ERR;
        default:                        lane_out.oct = XG_ERR;
      endcase
    end
  end
endmodule

// File: rtl/xlt_pipe_reg.sv
module xlt_pipe_reg #(
  parameter int unsigned WIDTH = 72
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [WIDTH-1:0] s_payload,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [WIDTH-1:0] m_payload
);
  logic             full_q;
  logic [WIDTH-1:0] hold_q;
  logic             take;

  assign s_ready = !full_q || m_ready;
  assign take    = s_valid && s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (s_ready) begin
      full_q <= s_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (take) begin
      hold_q <= s_payload;
    end
  end

  assign m_valid   = full_q;
  assign m_payload = hold_q;
endmodule

// File: rtl/xgmii_rx_xlate.sv
module xgmii_rx_xlate
  import xlt_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*OCT_W-1:0] in_data,
  input  logic [LANES-1:0]       in_ctrl,
  input  logic [LANES-1:0]       in_derr,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*OCT_W-1:0] out_data,
  output logic [LANES-1:0]       out_ctrl
);
  localparam int unsigned DW = LANES * OCT_W;
  localparam int unsigned PW = DW + LANES;

  lane_t [LANES-1:0]       mapped;
  logic  [DW-1:0]          map_data;
  logic  [LANES-1:0]       map_ctrl;
  logic  [PW-1:0]          reg_out;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    xlt_lane_map #(.LANE_IDX(g)) u_map (
      .oct_in  (in_data[g*OCT_W +: OCT_W]),
      .ctl_in  (in_ctrl[g]),
      .err_in  (in_derr[g]),
      .lane_out(mapped[g])
    );
    assign map_data[g*OCT_W +: OCT_W] = mapped[g].oct;
    assign map_ctrl[g]                = mapped[g].ctl;
  end

  xlt_pipe_reg #(.WIDTH(PW)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_valid  (in_valid),
    .s_ready  (in_ready),
    .s_payload({map_ctrl, map_data}),
    .m_valid  (out_valid),
    .m_ready  (out_ready),
    .m_payload(reg_out)
  );

  assign out_data = reg_out[DW-1:0];
  assign out_ctrl = reg_out[PW-1:DW];
endmodule

// File: rtl/xgmii_rx_xlate_chk.sv
module xgmii_rx_xlate_chk #(
  parameter int unsigned LANES = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [LANES*8-1:0]   out_data,
  input logic [LANES-1:0]     out_ctrl
);
  p_reset_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ctrl)));

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] oc;
    logic       legal;
    assign oc = out_data[g*8 +: 8];
    if (g == 0) begin : g_lead
      assign legal = (oc == 8'h07) || (oc == 8'hFD) || (oc == 8'hFE) ||
                     (oc == 8'hFB) || (oc == 8'h9C);
    end else begin : g_other
      assign legal = (oc == 8'h07) || (oc == 8'hFD) || (oc == 8'hFE);
    end
    // covers the lane-position rule (R4) and the reserved-value fold (R5)
    p_ctrl_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ctrl[g]) |-> legal);
  end
endmodule

bind xgmii_rx_xlate xgmii_rx_xlate_chk #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_ctrl (out_ctrl)
);

// File: tb/xgmii_rx_xlate_tb.sv
module xgmii_rx_xlate_tb;
  localparam int L  = 8;
  localparam int DW = L * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic [L-1:0]  in_ctrl = '0;
  logic [L-1:0]  in_derr = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic [L-1:0]  out_ctrl;

  int checks = 0;
  int fails  = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;

  logic [DW-1:0] exp_d_q[$];
  logic [L-1:0]  exp_c_q[$];
  string         tag_q[$];

  always #5 clk = ~clk;

  xgmii_rx_xlate #(.LANES(L)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ctrl(in_ctrl), .in_derr(in_derr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ctrl(out_ctrl)
  );

  // expected lane result, {ctrl, octet}, from the requirements
  function automatic logic [8:0] lane_model(int idx, logic [7:0] d, logic c, logic e);
    if (e) return {1'b1, 8'hFE};                          // R6
    if (!c) return {1'b0, d};                             // R1
    case (d)
      8'hBC, 8'h1C, 8'h7C: return {1'b1, 8'h07};          // R2
      8'hFD, 8'hFE:        return {1'b1, d};              // R3
      8'hFB, 8'h9C:        return (idx == 0) ? {1'b1, d} : {1'b1, 8'hFE}; // R4
      default:             return {1'b1, 8'hFE};          // R5
    endcase
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [DW-1:0] d, input logic [L-1:0] c,
                      input logic [L-1:0] e, input string tag);
    logic [DW-1:0] ed;
    logic [L-1:0]  ec;
    for (int i = 0; i < L; i++) begin
      logic [8:0] r;
      r = lane_model(i, d[i*8 +: 8], c[i], e[i]);
      ed[i*8 +: 8] = r[7:0];
      ec[i]        = r[8];
    end
    @(negedge clk);
    in_data = d; in_ctrl = c; in_derr = e; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    exp_d_q.push_back(ed); exp_c_q.push_back(ec); tag_q.push_back(tag);
    @(posedge clk);
    #1 in_valid = 1'b0;
    if (!stall_en) begin
      @(negedge clk);
      check("R7 latency", {127'd0, out_valid}, 128'd1);
    end
  endtask

  // output-ready driver
  initial begin
    forever begin
      @(posedge clk);
      #1 out_ready = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    logic [DW-1:0] last_d;
    logic [L-1:0]  last_c;
    bit            held;
    held = 1'b0;
    last_d = '0;
    last_c = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (held) begin
          check("R8 hold", {63'd0, out_valid, out_ctrl, out_data},
                {63'd0, 1'b1, last_c, last_d});
        end
        if (out_valid && out_ready) begin
          if (exp_d_q.size() == 0) begin
            check("R7 unexpected beat", {63'd0, out_ctrl, out_data}, 128'd0);
          end else begin
            logic [DW-1:0] ed;
            logic [L-1:0]  ec;
            string         t;
            ed = exp_d_q.pop_front(); ec = exp_c_q.pop_front(); t = tag_q.pop_front();
            check(t, {64'd0, out_ctrl, out_data}, {64'd0, ec, ed});
          end
        end
        held   = out_valid && !out_ready;
        last_d = out_data;
        last_c = out_ctrl;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset valid", {127'd0, out_valid}, 128'd0);
    check("R9 reset ready", {127'd0, in_ready}, 128'd1);

    // R1 plain data
    send(64'h0123_4567_89AB_CDEF, 8'h00, 8'h00, "R1");
    send(64'hFBFE_FD9C_BC1C_7C07, 8'h00, 8'h00, "R1 code-like data");
    // R2 fill characters
    send({8{8'hBC}}, 8'hFF, 8'h00, "R2 comma");
    send(64'h1C7C_BC1C_7CBC_1C7C, 8'hFF, 8'h00, "R2 mixed fill");
    // R3 terminate / error anywhere
    send(64'hFDFE_FDFE_FDFE_FDFE, 8'hFF, 8'h00, "R3");
    send(64'h0011_22FD_0707_07FE, 8'h19, 8'h00, "R3 mixed");
    // R4 lane-0 rule
    send(64'h5555_5555_5555_55FB, 8'h01, 8'h00, "R4 start lane0");
    send(64'h1111_1111_1111_119C, 8'h01, 8'h00, "R4 seq lane0");
    send(64'h9CFB_9CFB_9CFB_9CFB, 8'hFF, 8'h00, "R4 lanes 1..7");
    // R5 reserved codes
    send(64'h0007_FCFF_5A06_089B, 8'hFF, 8'h00, "R5");
    // R6 decode error
    send(64'h0123_4567_89AB_CDEF, 8'h00, 8'hA5, "R6 data");
    send(64'hBCFB_FD1C_7C9C_FEFB, 8'hFF, 8'h5A, "R6 ctrl");
    // R7 drain: no new beat, output taken
    repeat (2) @(negedge clk);
    check("R7 drain", {127'd0, out_valid}, 128'd0);

    // R8 random with back-pressure
    stall_en = 1'b1;
    for (int n = 0; n < 300; n++) begin
      logic [DW-1:0] d;
      logic [L-1:0]  c, e;
      for (int i = 0; i < L; i++) begin
        case ($urandom_range(0, 7))
          0: d[i*8 +: 8] = 8'hBC;
          1: d[i*8 +: 8] = 8'h1C;
          2: d[i*8 +: 8] = 8'h7C;
          3: d[i*8 +: 8] = 8'hFB;
          4: d[i*8 +: 8] = 8'h9C;
          5: d[i*8 +: 8] = 8'hFD;
          default: d[i*8 +: 8] = 8'($urandom);
        endcase
      end
      c = 8'($urandom);
      e = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h00;
      send(d, c, e, "R8 random");
    end
    while (exp_d_q.size() != 0) @(negedge clk);
    stall_en = 1'b0;
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule